// File: doc/BRIEF.md
# Dual-Processor Shared Work-RAM Bank Arbiter

This block holds a shared work RAM built from two equal halves, a low half and a high half, and hands them out to two processors, A and B, according to a 2-bit ownership mode. Each processor has its own request port carrying a window offset, a read/write strobe, an access size and write data. The block turns each access into a physical half and word index, or marks it as unmapped when the requesting processor owns nothing in the current mode. Processor B also has a private fallback RAM. When the mode gives B no shared memory, its window accesses go to that private RAM instead.

The two halves never share an owner inside one mode, so each half is a plain single-port bank. Both processors are served in the same clock cycle, with no arbitration and no stall. Read data and the unmapped flag come out registered, one cycle after the request. Only processor A writes the mode register. Processor B sees the full register byte on a read-back port.

Sizes are parameters. `HALF_AW` is the byte-address width of one half and `PRIV_AW` is that of B's private RAM. A full-size system uses 14 and 16, which gives 16 KiB halves, a 32 KiB window and a 64 KiB private RAM. The defaults are smaller so that elaboration stays light.

Top module: `dual_wram_arbiter`

## Requirements
- R1: The mode register is 8 bits wide and resets to 0x00. It is written whole from `modeWrData` when `modeWrEn` is high. `modeRdData` shows the new byte from the cycle after the write. Accesses made in the same cycle as the write still use the old mode. Bits [1:0] select the mode.
- R2: In mode 00, A owns the whole window. Offset bit `HALF_AW` selects the high half (1) or the low half (0). B accesses go to its private RAM, indexed by `bOffset[PRIV_AW-1:0]`.
- R3: In mode 01, A owns only the high half and B owns only the low half. For both processors, offset bit `HALF_AW` is ignored, so the half mirrors across the window.
- R4: In mode 10, A owns only the low half and B owns only the high half. Both are mirrored as in R3.
- R5: In mode 11, B owns the whole window, with offset bit `HALF_AW` selecting the half. A owns nothing.
- R6: An access by a processor that owns nothing raises its unmapped flag in the next cycle. Such a read returns zero. Such a write changes no memory byte.
- R7: Size code 00 is a byte, 01 is a halfword and 10 or 11 is a word. The address is aligned by clearing offset bit 0 for a halfword and bits [1:0] for a word.
- R8: Data is little-endian. The byte at aligned offset o sits in bits 8*(o mod 4)+7 down to 8*(o mod 4) of its 32-bit word. A read returns the addressed bytes zero-extended into the low bits. A write changes only the addressed bytes.
- R9: Requests from A and B in the same cycle are both carried out. Read data appears on `aRdata`/`bRdata` in the cycle after the request. It is zero in a cycle after a write or after no request.
- R10: B's unmapped flag is never raised. A's flag stays low for every access in modes 00, 01 and 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeWrEn | input | 1 | Processor A mode-register write strobe |
| modeWrData | input | 8 | Mode-register write byte |
| modeRdData | output | 8 | Mode-register read-back byte for processor B |
| aReq | input | 1 | Processor A request valid |
| aWe | input | 1 | Processor A write (1) or read (0) |
| aSize | input | 2 | Processor A access size code |
| aOffset | input | HALF_AW+1 | Processor A window byte offset |
| aWdata | input | 32 | Processor A write data, right-aligned |
| aRdata | output | 32 | Processor A read data, zero-extended |
| aUnmapped | output | 1 | Processor A access hit no owned memory |
| bReq | input | 1 | Processor B request valid |
| bWe | input | 1 | Processor B write (1) or read (0) |
| bSize | input | 2 | Processor B access size code |
| bOffset | input | PRIV_AW | Processor B byte offset (shared window uses the low HALF_AW+1 bits) |
| bWdata | input | 32 | Processor B write data, right-aligned |
| bRdata | output | 32 | Processor B read data, zero-extended |
| bUnmapped | output | 1 | Processor B access hit no owned memory |

## Verification
The state that can go wrong is the ownership mode and the read routing captured beside each access. A bad mode shows at once as the wrong unmapped flag on the cycle after the next request. It also shows as data from the wrong half or from the private RAM. A lost or misrouted write stays hidden until that location is read back. For that reason every mode is filled with mixed-size, misaligned writes on both ports together, then read back at every byte offset in every size. A final pass in mode 00 exposes any write that mode 11 should have discarded.

// File: rtl/wram_arb_pkg.sv
package wram_arb_pkg;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_LO   = 2'd1,
    SRC_HI   = 2'd2,
    SRC_PRIV = 2'd3
  } srcSel_e;

  typedef struct packed {
    logic       en;
    logic       we;
    logic       fromB;
    logic [3:0] be;
  } memStb_t;

  typedef struct packed {
    memStb_t    lo;
    memStb_t    hi;
    memStb_t    priv;
    srcSel_e    aRdSrc;
    srcSel_e    bRdSrc;
    logic       aMiss;
    logic       bMiss;
    logic [1:0] aLane;
    logic [1:0] bLane;
    logic [1:0] aSz;
    logic [1:0] bSz;
  } ctrlStb_t;

  function automatic logic [1:0] alignLane(input logic [1:0] sz, input logic [1:0] low);
    case (sz)
      2'b00:   return low;
      2'b01:   return {low[1], 1'b0};
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic [3:0] laneMask(input logic [1:0] sz, input logic [1:0] lane);
    case (sz)
      2'b00:   return 4'b0001 << lane;
      2'b01:   return lane[1] ? 4'b1100 : 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

endpackage

// File: rtl/wram_arb_ctrl.sv
module wram_arb_ctrl
  import wram_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       modeWrEn,
  input  logic [7:0] modeWrData,
  output logic [7:0] modeRaw,
  input  logic       aReq,
  input  logic       aWe,
  input  logic [1:0] aSize,
  input  logic       aHiBit,
  input  logic [1:0] aLow,
  input  logic       bReq,
  input  logic       bWe,
  input  logic [1:0] bSize,
  input  logic       bHiBit,
  input  logic [1:0] bLow,
  output ctrlStb_t   stb
);

  logic [7:0] modeReg;
  logic [1:0] mode;
  srcSel_e    aSrc, bSrc;
  logic [1:0] aLane, bLane;
  logic [3:0] aBe, bBe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         modeReg <= '0;
    else if (modeWrEn) modeReg <= modeWrData;
  end

  assign modeRaw = modeReg;
  assign mode    = modeReg[1:0];

  always_comb begin
    case (mode)
      2'b00: begin
        aSrc = aHiBit ? SRC_HI : SRC_LO;
        bSrc = SRC_PRIV;
      end
      2'b01: begin
        aSrc = SRC_HI;
        bSrc = SRC_LO;
      end
      2'b10: begin
        aSrc = SRC_LO;
        bSrc = SRC_HI;
      end
      default: begin
        aSrc = SRC_NONE;
        bSrc = bHiBit ? SRC_HI : SRC_LO;
      end
    endcase
  end

  assign aLane = alignLane(aSize, aLow);
  assign bLane = alignLane(bSize, bLow);
  assign aBe   = laneMask(aSize, aLane);
  assign bBe   = laneMask(bSize, bLane);

  function automatic memStb_t bankStb(input srcSel_e which);
    memStb_t s;
    logic    aHit, bHit;
    aHit    = aReq && (aSrc == which);
    bHit    = bReq && (bSrc == which);
    s.en    = aHit || bHit;
    s.fromB = bHit;
    s.we    = bHit ? bWe : aWe;
    s.be    = bHit ? bBe : aBe;
    return s;
  endfunction

  always_comb begin
    stb.lo     = bankStb(SRC_LO);
    stb.hi     = bankStb(SRC_HI);
    stb.priv   = bankStb(SRC_PRIV);
    stb.aRdSrc = (aReq && !aWe) ? aSrc : SRC_NONE;
    stb.bRdSrc = (bReq && !bWe) ? bSrc : SRC_NONE;
    stb.aMiss  = aReq && (aSrc == SRC_NONE);
    stb.bMiss  = bReq && (bSrc == SRC_NONE);
    stb.aLane  = aLane;
    stb.bLane  = bLane;
    stb.aSz    = aSize;
    stb.bSz    = bSize;
  end

endmodule

// File: rtl/wram_arb_bank.sv
module wram_arb_bank #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             en,
  input  logic             we,
  input  logic [3:0]       be,
  input  logic [IDX_W-1:0] idx,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata
);

  localparam int DEPTH = 1 << IDX_W;

  logic [31:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) begin
        for (int b = 0; b < 4; b++) begin
          if (be[b]) mem[idx][8*b +: 8] <= wdata[8*b +: 8];
        end
      end
      rdata <= mem[idx];
    end
  end

endmodule

// File: rtl/wram_arb_dpath.sv
module wram_arb_dpath
  import wram_arb_pkg::*;
#(
  parameter int HALF_AW = 8,
  parameter int PRIV_AW = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStb_t           stb,
  input  logic [HALF_AW-3:0] aIdx,
  input  logic [PRIV_AW-3:0] bIdx,
  input  logic [31:0]        aWdata,
  input  logic [31:0]        bWdata,
  output logic [31:0]        aRdata,
  output logic [31:0]        bRdata,
  output logic               aUnmapped,
  output logic               bUnmapped
);

  localparam int HIDX_W = HALF_AW - 2;
  localparam int PIDX_W = PRIV_AW - 2;

  function automatic logic [31:0] spread(input logic [1:0] sz, input logic [31:0] d);
    case (sz)
      2'b00:   return {4{d[7:0]}};
      2'b01:   return {2{d[15:0]}};
      default: return d;
    endcase
  endfunction

  function automatic logic [31:0] extract(input logic [31:0] w, input logic [1:0] lane,
                                          input logic [1:0] sz);
    logic [31:0] sh;
    sh = w >> {lane, 3'b000};
    case (sz)
      2'b00:   return {24'd0, sh[7:0]};
      2'b01:   return {16'd0, sh[15:0]};
      default: return sh;
    endcase
  endfunction

  logic [31:0] aWr, bWr;
  logic [31:0] loQ, hiQ, privQ;
  srcSel_e     aSrcQ, bSrcQ;
  logic [1:0]  aLaneQ, bLaneQ, aSzQ, bSzQ;

  assign aWr = spread(stb.aSz, aWdata);
  assign bWr = spread(stb.bSz, bWdata);

  wram_arb_bank #(.IDX_W(HIDX_W)) loBank (
    .clk   (clk),
    .en    (stb.lo.en),
    .we    (stb.lo.we),
    .be    (stb.lo.be),
    .idx   (stb.lo.fromB ? bIdx[HIDX_W-1:0] : aIdx),
    .wdata (stb.lo.fromB ? bWr : aWr),
    .rdata (loQ)
  );

  wram_arb_bank #(.IDX_W(HIDX_W)) hiBank (
    .clk   (clk),
    .en    (stb.hi.en),
    .we    (stb.hi.we),
    .be    (stb.hi.be),
    .idx   (stb.hi.fromB ? bIdx[HIDX_W-1:0] : aIdx),
    .wdata (stb.hi.fromB ? bWr : aWr),
    .rdata (hiQ)
  );

  wram_arb_bank #(.IDX_W(PIDX_W)) privBank (
    .clk   (clk),
    .en    (stb.priv.en && stb.priv.fromB),
    .we    (stb.priv.we),
    .be    (stb.priv.be),
    .idx   (bIdx),
    .wdata (bWr),
    .rdata (privQ)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aSrcQ     <= SRC_NONE;
      bSrcQ     <= SRC_NONE;
      aLaneQ    <= '0;
      bLaneQ    <= '0;
      aSzQ      <= '0;
      bSzQ      <= '0;
      aUnmapped <= 1'b0;
      bUnmapped <= 1'b0;
    end else begin
      aSrcQ     <= stb.aRdSrc;
      bSrcQ     <= stb.bRdSrc;
      aLaneQ    <= stb.aLane;
      bLaneQ    <= stb.bLane;
      aSzQ      <= stb.aSz;
      bSzQ      <= stb.bSz;
      aUnmapped <= stb.aMiss;
      bUnmapped <= stb.bMiss;
    end
  end

  function automatic logic [31:0] pick(input srcSel_e s, input logic [31:0] lo,
                                       input logic [31:0] hi, input logic [31:0] pv);
    case (s)
      SRC_LO:   return lo;
      SRC_HI:   return hi;
      SRC_PRIV: return pv;
      default:  return 32'd0;
    endcase
  endfunction

  assign aRdata = extract(pick(aSrcQ, loQ, hiQ, privQ), aLaneQ, aSzQ);
  assign bRdata = extract(pick(bSrcQ, loQ, hiQ, privQ), bLaneQ, bSzQ);

endmodule

// File: rtl/dual_wram_arbiter.sv
module dual_wram_arbiter
  import wram_arb_pkg::*;
#(
  parameter int HALF_AW = 8,
  parameter int PRIV_AW = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               modeWrEn,
  input  logic [7:0]         modeWrData,
  output logic [7:0]         modeRdData,
  input  logic               aReq,
  input  logic               aWe,
  input  logic [1:0]         aSize,
  input  logic [HALF_AW:0]   aOffset,
  input  logic [31:0]        aWdata,
  output logic [31:0]        aRdata,
  output logic               aUnmapped,
  input  logic               bReq,
  input  logic               bWe,
  input  logic [1:0]         bSize,
  input  logic [PRIV_AW-1:0] bOffset,
  input  logic [31:0]        bWdata,
  output logic [31:0]        bRdata,
  output logic               bUnmapped
);

  ctrlStb_t stb;

  wram_arb_ctrl ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .modeWrEn   (modeWrEn),
    .modeWrData (modeWrData),
    .modeRaw    (modeRdData),
    .aReq       (aReq),
    .aWe        (aWe),
    .aSize      (aSize),
    .aHiBit     (aOffset[HALF_AW]),
    .aLow       (aOffset[1:0]),
    .bReq       (bReq),
    .bWe        (bWe),
    .bSize      (bSize),
    .bHiBit     (bOffset[HALF_AW]),
    .bLow       (bOffset[1:0]),
    .stb        (stb)
  );

  wram_arb_dpath #(.HALF_AW(HALF_AW), .PRIV_AW(PRIV_AW)) dpath (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .aIdx      (aOffset[HALF_AW-1:2]),
    .bIdx      (bOffset[PRIV_AW-1:2]),
    .aWdata    (aWdata),
    .bWdata    (bWdata),
    .aRdata    (aRdata),
    .bRdata    (bRdata),
    .aUnmapped (aUnmapped),
    .bUnmapped (bUnmapped)
  );

endmodule

// File: rtl/wram_arb_checker.sv
module wram_arb_checker (
  input logic        clk,
  input logic        rstN,
  input logic        modeWrEn,
  input logic [7:0]  modeWrData,
  input logic [7:0]  modeRdData,
  input logic        aReq,
  input logic        aWe,
  input logic [1:0]  aSize,
  input logic [31:0] aRdata,
  input logic        aUnmapped,
  input logic        bReq,
  input logic        bUnmapped
);

  assert_mode_load_R1: assert property (@(posedge clk) disable iff (!rstN)
    modeWrEn |=> modeRdData == $past(modeWrData));

  assert_mode_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    !modeWrEn |=> $stable(modeRdData));

  assert_a_locked_out_R5: assert property (@(posedge clk) disable iff (!rstN)
    (aReq && modeRdData[1:0] == 2'b11) |=> aUnmapped);

  assert_a_owned_R10: assert property (@(posedge clk) disable iff (!rstN)
    (aReq && modeRdData[1:0] != 2'b11) |=> !aUnmapped);

  assert_b_never_miss_R10: assert property (@(posedge clk) disable iff (!rstN)
    bReq |=> !bUnmapped);

  assert_miss_reads_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    aUnmapped |-> aRdata == 32'd0);

  assert_byte_zero_ext_R8: assert property (@(posedge clk) disable iff (!rstN)
    (aReq && !aWe && aSize == 2'b00) |=> aRdata[31:8] == 24'd0);

endmodule

bind dual_wram_arbiter wram_arb_checker chk (
  .clk        (clk),
  .rstN       (rstN),
  .modeWrEn   (modeWrEn),
  .modeWrData (modeWrData),
  .modeRdData (modeRdData),
  .aReq       (aReq),
  .aWe        (aWe),
  .aSize      (aSize),
  .aRdata     (aRdata),
  .aUnmapped  (aUnmapped),
  .bReq       (bReq),
  .bUnmapped  (bUnmapped)
);

// File: tb/dual_wram_arbiter_test.sv
module dual_wram_arbiter_test;

  localparam int HA   = 6;
  localparam int PA   = 8;
  localparam int HALF = 1 << HA;
  localparam int WIN  = 2 * HALF;
  localparam int PRIV = 1 << PA;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        modeWrEn = 1'b0;
  logic [7:0]  modeWrData = '0;
  logic [7:0]  modeRdData;
  logic        aReq = 1'b0, aWe = 1'b0;
  logic [1:0]  aSize = '0;
  logic [HA:0] aOffset = '0;
  logic [31:0] aWdata = '0;
  logic [31:0] aRdata;
  logic        aUnmapped;
  logic        bReq = 1'b0, bWe = 1'b0;
  logic [1:0]  bSize = '0;
  logic [PA-1:0] bOffset = '0;
  logic [31:0] bWdata = '0;
  logic [31:0] bRdata;
  logic        bUnmapped;

  int total = 0;
  int bad = 0;
  int curMode = 0;
  logic [7:0] model [WIN + PRIV];

  always #5 clk = ~clk;

  dual_wram_arbiter #(.HALF_AW(HA), .PRIV_AW(PA)) uut (
    .clk(clk), .rstN(rstN), .modeWrEn(modeWrEn), .modeWrData(modeWrData),
    .modeRdData(modeRdData), .aReq(aReq), .aWe(aWe), .aSize(aSize),
    .aOffset(aOffset), .aWdata(aWdata), .aRdata(aRdata), .aUnmapped(aUnmapped),
    .bReq(bReq), .bWe(bWe), .bSize(bSize), .bOffset(bOffset), .bWdata(bWdata),
    .bRdata(bRdata), .bUnmapped(bUnmapped)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic string modeTag(input int m);
    case (m)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  function automatic int sizeBytes(input logic [1:0] s);
    return (s == 2'b00) ? 1 : (s == 2'b01) ? 2 : 4;
  endfunction

  // model index of the first byte, or -1 when the processor owns nothing (R2..R5, R7)
  function automatic int mapA(input int m, input int addr);
    int off;
    off = addr & (WIN - 1);
    case (m)
      0: return off;
      1: return HALF + (off & (HALF - 1));
      2: return off & (HALF - 1);
      default: return -1;
    endcase
  endfunction

  function automatic int mapB(input int m, input int addr);
    int off;
    off = addr & (WIN - 1);
    case (m)
      0: return WIN + (addr & (PRIV - 1));
      1: return off & (HALF - 1);
      2: return HALF + (off & (HALF - 1));
      default: return off;
    endcase
  endfunction

  function automatic logic [31:0] readModel(input int base, input int n);
    logic [31:0] v = '0;
    for (int k = 0; k < n; k++) v[8*k +: 8] = model[base + k];
    return v;
  endfunction

  task automatic writeModel(input int base, input int n, input logic [31:0] d);
    for (int k = 0; k < n; k++) model[base + k] = d[8*k +: 8];
  endtask

  // one request cycle on both ports; results sampled at the following falling edge (R9)
  task automatic step(input string tag);
    int na, nb, ia, ib, nextMode;
    logic [31:0] expA, expB;
    bit rdA, rdB;
    na = sizeBytes(aSize);
    nb = sizeBytes(bSize);
    ia = mapA(curMode, int'(aOffset) & ~(na - 1));
    ib = mapB(curMode, int'(bOffset) & ~(nb - 1));
    rdA = aReq && !aWe;
    rdB = bReq && !bWe;
    expA = (rdA && ia >= 0) ? readModel(ia, na) : 32'd0;
    expB = (rdB && ib >= 0) ? readModel(ib, nb) : 32'd0;
    if (aReq && aWe && ia >= 0) writeModel(ia, na, aWdata);
    if (bReq && bWe && ib >= 0) writeModel(ib, nb, bWdata);
    nextMode = modeWrEn ? int'(modeWrData[1:0]) : curMode;
    @(posedge clk);
    #1 modeWrEn = 1'b0;
    @(negedge clk);
    if (aReq) check(aUnmapped == (ia < 0), {tag, " R6 R10 a-flag"}, 32'(aUnmapped), 32'(ia < 0));
    if (bReq) check(bUnmapped == 1'b0, {tag, " R10 b-flag"}, 32'(bUnmapped), 32'd0);
    if (rdA) check(aRdata == expA, {tag, " R7 R8 R9 a-read"}, aRdata, expA);
    if (rdB) check(bRdata == expB, {tag, " R7 R8 R9 b-read"}, bRdata, expB);
    curMode = nextMode;
    aReq = 1'b0;
    bReq = 1'b0;
  endtask

  task automatic setMode(input int m);
    logic [7:0] v;
    v = 8'hA4 | 8'(m);
    modeWrEn = 1'b1;
    modeWrData = v;
    step("R1 mode-write");
    check(modeRdData == v, "R1 readback", {24'd0, modeRdData}, {24'd0, v});
  endtask

  function automatic logic [31:0] pattern(input int m, input int i, input int port);
    return (32'(i) * 32'h0103_0507) ^ (32'(m) << 28) ^ (32'(port) << 24) ^ 32'h5A00_C3A5;
  endfunction

  initial begin
    #2_000_000;
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(modeRdData == 8'h00, "R1 reset mode", {24'd0, modeRdData}, 32'd0);
    check(aUnmapped == 1'b0, "R6 reset flag", 32'(aUnmapped), 32'd0);
    check(aRdata == 32'd0, "R9 reset rdata", aRdata, 32'd0);

    // fill shared (from A) and private (from B) with words in mode 00
    for (int i = 0; i < PRIV / 4; i++) begin
      aReq = 1'b1; aWe = 1'b1; aSize = 2'b10;
      aOffset = (HA+1)'((i * 4) & (WIN - 1)); aWdata = pattern(9, i, 0);
      bReq = 1'b1; bWe = 1'b1; bSize = 2'b10;
      bOffset = PA'(i * 4); bWdata = pattern(9, i, 1);
      step("R2 fill");
    end

    // old mode still applies in the cycle of the mode write (R1)
    modeWrEn = 1'b1; modeWrData = 8'h03;
    aReq = 1'b1; aWe = 1'b0; aSize = 2'b10; aOffset = '0;
    step("R1 same-cycle");
    check(modeRdData == 8'h03, "R1 readback", {24'd0, modeRdData}, 32'h03);
    aReq = 1'b1; aWe = 1'b0; aSize = 2'b10; aOffset = '0;
    step("R5 next-cycle");

    for (int m = 0; m < 4; m++) begin
      setMode(m);
      // mixed-size misaligned writes on both ports together (R7, R8, R9)
      for (int i = 0; i < PRIV / 4; i++) begin
        aReq = 1'b1; aWe = 1'b1; aSize = 2'(i % 3);
        aOffset = (HA+1)'((i * 4 + ((i * 5) & 3)) & (WIN - 1)); aWdata = pattern(m, i, 0);
        bReq = 1'b1; bWe = 1'b1; bSize = 2'((i + 1) % 3);
        bOffset = PA'(i * 4 + ((i * 3) & 3)); bWdata = pattern(m, i, 1);
        step(modeTag(m));
      end
      // read back every offset in every size
      for (int j = 0; j < PRIV; j++) begin
        for (int s = 0; s < 3; s++) begin
          aReq = 1'b1; aWe = 1'b0; aSize = 2'(s); aOffset = (HA+1)'(j & (WIN - 1));
          bReq = 1'b1; bWe = 1'b0; bSize = 2'(s); bOffset = PA'(j);
          step(modeTag(m));
        end
      end
    end

    // writes issued by A in mode 11 must have left the shared RAM untouched (R6)
    setMode(0);
    for (int i = 0; i < WIN / 4; i++) begin
      aReq = 1'b1; aWe = 1'b0; aSize = 2'b10; aOffset = (HA+1)'(i * 4);
      step("R6 discard");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule